// File: doc/BRIEF.md
# Daisy-Chain Bus Grant Arbiter

This block arbitrates one shared bus among devices laid out along daisy chains. Each device's request is merged with the others by OR into a single request line per priority level, and all devices share one busy line. When the bus is quiet and a request is present, a central controller drives a grant into the chain of the most urgent level. The grant then ripples along that chain one registered stage per clock. A stage whose device is requesting keeps the grant. A stage whose device is not requesting hands it to its neighbour. Priority inside a level therefore comes from position: the stage nearest the controller wins.

The winning device sees its `dev_win` output rise and asserts its busy input for as long as its transfer lasts. The controller withdraws the grant once busy is seen. It also withdraws the grant if every request on the offered level disappears. After any withdrawal, it waits long enough for the old grant wave to drain from the longest chain before it makes a new offer.

Device numbering is `level * N_DEV + position`. Position 0 is nearest the controller, and level 0 is the most urgent.

Top module: `dc_chain_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, every `lvl_grant` and `dev_win` bit is 0 after that edge, whatever the requests are.
- R2: With the controller idle, all busy inputs low and at least one request high, `lvl_grant` becomes nonzero at the next clock edge.
- R3: No new grant is issued while any busy input is high.
- R4: A device at position k whose level is granted, with no requester ahead of it, sees `dev_win` rise k+1 edges after `lvl_grant` rises.
- R5: Within the granted level, the requester at the lowest position wins. At most one `dev_win` bit is ever high.
- R6: A grant is withdrawn at the first edge at which busy is sampled high while the grant stands.
- R7: A grant is withdrawn at the first edge at which the offered level has no request high.
- R8: At issue time the grant goes only to the lowest-numbered level with a request. At most one `lvl_grant` bit is ever high.
- R9: While an offer stands and the bus is not busy, a request on a more urgent level does not move the grant.
- R10: A winner that drops its request loses `dev_win` at the next edge, and the grant continues down the chain to the next requester.
- R11: After a withdrawal, no grant is issued for N_DEV edges. The earliest new grant appears at the (N_DEV+1)th edge.
- R12: A stage that has passed the grant on does not claim it later during the same offer, even if its device starts requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req | input | N_LVL*N_DEV | Per-device request, index level*N_DEV+position |
| dev_busy | input | N_LVL*N_DEV | Per-device busy drive, merged by OR |
| dev_win | output | N_LVL*N_DEV | Device holds the grant after a full cycle of grant-in |
| lvl_grant | output | N_LVL | Grant driven into the head of each level chain |
| bus_busy | output | 1 | Merged busy line |

## Verification
The hardest situations to reach from the ports are races between the rippling grant and requests that change while it travels. Examples are a stage that starts requesting just after it has passed the grant on, a winner that gives up before asserting busy, and a re-request during the drain window after a withdrawal. The bench reaches each of these by changing `dev_req` at a chosen negedge counted from the grant's rise. This is possible because the latency to every position is known exactly. A vector table covers position and level priority, with the bus released between vectors.

// File: rtl/dc_arb_pkg.sv
// Shared types for the daisy-chain arbiter.
package dc_arb_pkg;
    // Controller phases: waiting, offering a grant, draining the chains.
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_OFFER = 2'd1,
        ARB_DRAIN = 2'd2
    } arb_state_e;
endpackage

// File: rtl/dc_arb_stage.sv
// One link of a grant chain. It registers both decisions, so the grant
// costs one cycle per link. Once the link has passed the grant on, it keeps
// passing until grant_in falls. Assumes grant_in comes from a register.
module dc_arb_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_in,
    input  logic dev_req,
    output logic grant_out,
    output logic dev_win
);
    logic pass_q;
    logic keep_q;
    logic keep_n;
    logic pass_n;

    // Decide: keep if requesting and not already passing, otherwise pass.
    always_comb begin
        keep_n = grant_in & dev_req & ~pass_q;
        pass_n = grant_in & ~keep_n;
    end

    // Register the keep and pass decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
            keep_q <= 1'b0;
        end else begin
            pass_q <= pass_n;
            keep_q <= keep_n;
        end
    end

    assign grant_out = pass_q;
    assign dev_win   = keep_q;

    // R12: a link that is passing never turns into the keeper during the offer.
    p_pass_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_q && grant_in) |=> !keep_q);
endmodule

// File: rtl/dc_arb_chain.sv
// One priority level: N_DEV links in series. The head link is fed by the
// level grant. The level request line is the OR of the device requests.
module dc_arb_chain #(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_grant,
    input  logic [N_DEV-1:0] dev_req,
    output logic [N_DEV-1:0] dev_win,
    output logic             chain_req
);
    logic [N_DEV:0] link;

    assign link[0]   = head_grant;
    assign chain_req = |dev_req;

    // Build the chain, link k feeding link k+1.
    for (genvar k = 0; k < N_DEV; k++) begin : g_link
        dc_arb_stage u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .grant_in  (link[k]),
            .dev_req   (dev_req[k]),
            .grant_out (link[k+1]),
            .dev_win   (dev_win[k])
        );
    end

    // R5: at most one link in the chain holds the grant.
    p_one_keeper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_win));
endmodule

// File: rtl/dc_arb_ctrl.sv
// Central controller. It offers a grant to the most urgent requesting
// level when the bus is idle, and withdraws it when busy rises or the
// level's requests vanish. It then waits N_DEV cycles so the old wave
// drains from every chain. Assumes lvl_req and bus_busy come from registers.
module dc_arb_ctrl
    import dc_arb_pkg::*;
#(
    parameter int N_LVL = 2,
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LVL-1:0] lvl_req,
    input  logic             bus_busy,
    output logic [N_LVL-1:0] lvl_grant
);
    localparam int CNT_W = $clog2(N_DEV + 1);

    arb_state_e       state_q;
    logic [CNT_W-1:0] drain_q;
    logic [N_LVL-1:0] grant_q;
    logic [N_LVL-1:0] pick_oh;

    // Lowest-numbered requesting level, as a one-hot vector.
    always_comb pick_oh = lvl_req & (~lvl_req + N_LVL'(1));

    // Sequence of offer, withdraw and drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            drain_q <= '0;
            grant_q <= '0;
        end else begin
            case (state_q)
                ARB_IDLE: begin
                    if (!bus_busy && (lvl_req != '0)) begin
                        grant_q <= pick_oh;
                        state_q <= ARB_OFFER;
                    end
                end
                ARB_OFFER: begin
                    if (bus_busy || ((grant_q & lvl_req) == '0)) begin
                        grant_q <= '0;
                        drain_q <= CNT_W'(N_DEV - 1);
                        state_q <= ARB_DRAIN;
                    end
                end
                default: begin
                    if (drain_q == '0) state_q <= ARB_IDLE;
                    else               drain_q <= drain_q - 1'b1;
                end
            endcase
        end
    end

    assign lvl_grant = grant_q;

    // R3: no grant appears while the bus is busy.
    p_no_grant_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q == '0 && bus_busy) |=> grant_q == '0);
    // R6: busy seen under a grant removes the grant.
    p_drop_on_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q != '0 && bus_busy) |=> grant_q == '0);
    // R7: an offer to a level without requests is withdrawn.
    p_withdraw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q != '0 && (grant_q & lvl_req) == '0) |=> grant_q == '0);
    // R8: at most one level granted.
    p_one_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));
    // R9: a standing offer on a requesting level is not moved.
    p_kept_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q != '0 && !bus_busy && (grant_q & lvl_req) != '0)
        |=> grant_q == $past(grant_q));
endmodule

// File: rtl/dc_chain_arbiter.sv
// Top level: one controller and N_LVL grant chains of N_DEV links each.
// Device index is level*N_DEV + position. Busy is the OR of all devices.
module dc_chain_arbiter #(
    parameter int N_LVL = 2,
    parameter int N_DEV = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_LVL*N_DEV-1:0] dev_req,
    input  logic [N_LVL*N_DEV-1:0] dev_busy,
    output logic [N_LVL*N_DEV-1:0] dev_win,
    output logic [N_LVL-1:0]       lvl_grant,
    output logic                   bus_busy
);
    logic [N_LVL-1:0] lvl_req;

    assign bus_busy = |dev_busy;

    dc_arb_ctrl #(.N_LVL(N_LVL), .N_DEV(N_DEV)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_req   (lvl_req),
        .bus_busy  (bus_busy),
        .lvl_grant (lvl_grant)
    );

    // One chain per priority level.
    for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
        dc_arb_chain #(.N_DEV(N_DEV)) u_chain (
            .clk        (clk),
            .rst_n      (rst_n),
            .head_grant (lvl_grant[l]),
            .dev_req    (dev_req[l*N_DEV +: N_DEV]),
            .dev_win    (dev_win[l*N_DEV +: N_DEV]),
            .chain_req  (lvl_req[l])
        );
    end

    // R5: across all levels, at most one device holds the grant.
    p_one_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_win));
endmodule

// File: tb/dc_chain_arbiter_tb_top.sv
module dc_chain_arbiter_tb_top;
    localparam int NL = 2;
    localparam int ND = 4;
    localparam int NV = 10;

    // Request patterns and the expected winner (level*ND + position).
    localparam logic [7:0] VEC_REQ [NV] = '{
        8'h01, 8'h02, 8'h08, 8'h0C, 8'h10, 8'h80, 8'h84, 8'h60, 8'hFF, 8'h0A};
    localparam int VEC_WIN [NV] = '{0, 1, 3, 2, 4, 7, 2, 5, 0, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] dev_req = '0;
    logic [7:0] dev_busy = '0;
    logic [7:0] dev_win;
    logic [1:0] lvl_grant;
    logic bus_busy;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dc_chain_arbiter #(.N_LVL(NL), .N_DEV(ND)) dut_i (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_busy(dev_busy),
        .dev_win(dev_win), .lvl_grant(lvl_grant), .bus_busy(bus_busy));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic release_all();
        dev_req = '0;
        dev_busy = '0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        // R1: reset with requests present.
        dev_req = 8'hFF;
        repeat (3) @(negedge clk);
        chk(lvl_grant == 0 && dev_win == 0, "R1 reset state", {lvl_grant, dev_win}, 0);
        dev_req = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(lvl_grant == 0 && dev_win == 0, "R1 after reset", {lvl_grant, dev_win}, 0);

        // R3 then R2: foreign busy blocks the offer; release gives grant next edge.
        dev_busy = 8'h20;
        dev_req = 8'h01;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(lvl_grant == 0 && dev_win == 0, "R3 busy blocks grant", {lvl_grant, dev_win}, 0);
        end
        dev_busy = '0;
        @(negedge clk);
        chk(lvl_grant == 2'b01, "R2 grant one edge after idle", lvl_grant, 1);
        release_all();

        // Table: position and level priority, ripple latency, busy withdrawal.
        for (int v = 0; v < NV; v++) begin
            int cyc;
            int w;
            w = VEC_WIN[v];
            dev_req = VEC_REQ[v];
            cyc = 0;
            while (dev_win == 0 && cyc < 20) begin
                @(negedge clk);
                cyc++;
            end
            chk(dev_win == 8'(1 << w), "R5 winner", dev_win, 1 << w);
            chk(cyc == (w % ND) + 2, "R4 ripple latency", cyc, (w % ND) + 2);
            chk(lvl_grant == 2'(1 << (w / ND)), "R8 level chosen", lvl_grant, 1 << (w / ND));
            dev_busy = 8'(1 << w);
            @(negedge clk);
            chk(lvl_grant == 0, "R6 withdraw on busy", lvl_grant, 0);
            release_all();
        end

        // R7 and R11: requests vanish mid-ripple, then the drain hold-off.
        dev_req = 8'h04;
        @(negedge clk);
        chk(lvl_grant == 2'b01, "R2 offer to level 0", lvl_grant, 1);
        @(negedge clk);
        dev_req = '0;
        @(negedge clk);
        chk(lvl_grant == 0, "R7 withdraw without requests", lvl_grant, 0);
        dev_req = 8'h01;
        for (int i = 0; i < ND; i++) begin
            @(negedge clk);
            chk(lvl_grant == 0 && dev_win == 0, "R11 drain hold-off", {lvl_grant, dev_win}, 0);
        end
        @(negedge clk);
        chk(lvl_grant == 2'b01, "R11 first grant after drain", lvl_grant, 1);
        release_all();

        // R9: level 1 offer is not moved by a later level 0 request.
        dev_req = 8'h10;
        @(negedge clk);
        chk(lvl_grant == 2'b10, "R8 lone level 1", lvl_grant, 2);
        dev_req = 8'h11;
        @(negedge clk);
        chk(lvl_grant == 2'b10 && dev_win == 8'h10, "R9 offer kept", {lvl_grant, dev_win}, 'h210);
        @(negedge clk);
        chk(lvl_grant == 2'b10, "R9 offer still kept", lvl_grant, 2);
        dev_busy = 8'h10;
        @(negedge clk);
        dev_busy = '0;
        dev_req = 8'h01;
        for (int i = 0; i < 15 && lvl_grant == 0; i++) @(negedge clk);
        chk(lvl_grant == 2'b01, "R8 level 0 served next", lvl_grant, 1);
        release_all();

        // R10: winner gives up, grant moves downstream.
        dev_req = 8'h0A;
        repeat (3) @(negedge clk);
        chk(dev_win == 8'h02, "R10 first winner", dev_win, 2);
        dev_req = 8'h08;
        @(negedge clk);
        chk(dev_win == 8'h00, "R10 win dropped", dev_win, 0);
        repeat (2) @(negedge clk);
        chk(dev_win == 8'h08, "R10 grant passed on", dev_win, 8);
        release_all();

        // R12: stage 0 starts requesting after it has passed the grant.
        dev_req = 8'h08;
        repeat (2) @(negedge clk);
        dev_req = 8'h09;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(dev_win == 0, "R12 no late claim", dev_win, 0);
        end
        @(negedge clk);
        chk(dev_win == 8'h08, "R12 original winner", dev_win, 8);
        release_all();

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule